// File: doc/BRIEF.md
# Decode-Stage Branch Redirect Unit

This unit sits on the output path of an instruction decode stage. Each cycle it receives a group of up to `W` slots. Every slot carries a thread number, a sequence number, a few control-flow attributes and two target addresses: the one the front-end predictor supplied and the one decode computed. The unit checks two things in each slot. First, that a slot the predictor marked as taken really is a control transfer. Second, that a direct unconditional branch was predicted to the target decode computed for it.

Slots are scanned from index 0 upward, and the first slot that fails a check becomes the offender. The offender is still passed downstream, with its target replaced by the computed one. A redirect record goes back to fetch, holding the offender's thread, its sequence number, the correct next PC and a taken flag. Every incoming slot of the same thread that is younger than the offender is flagged as squashed. No slot after the offender is forwarded that cycle.

Three free-running counters record activity:
- branches resolved at decode;
- branch target mispredicts;
- control mispredicts.

Every output is registered, so results appear one clock after the inputs.

Top module: `brx_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the cycle after it, `out_valid`, `out_sq` and `rd_valid` are 0 and all three counters are 0.
- R2: A slot is a resolvable branch when `valid`, `ctrl`, `direct` and `uncond` are all 1. `cnt_res` grows by the number of resolvable slots at or below the offender's index, or by the number in all slots when there is no offender.
- R3: A resolvable slot whose `ctgt` differs from its `ptgt` is a target mispredict. If it is the offender, the redirect has `rd_kind`=0 (target mispredict), `rd_taken`=1, `rd_npc` equal to that slot's `ctgt`, and the slot's `rd_tid` and `rd_seq`. `cnt_bm` then grows by 1.
- R4: A valid slot with `ptaken`=1 and `ctrl`=0 is a control mispredict. If it is the offender, the redirect has `rd_kind`=1 (control mispredict), `rd_taken`=0 and `rd_npc` equal to that slot's `ctgt`. `cnt_cm` then grows by 1.
- R5: Only the lowest-index mispredicting slot produces a redirect. At most one redirect is produced per cycle, and slots above the offender do not change any counter.
- R6: `out_sq[j]` is 1 exactly when a redirect occurs, slot j is valid, slot j's thread equals the offender's thread, and slot j's sequence number is strictly greater than the offender's. Sequence numbers are compared as plain unsigned values.
- R7: `out_valid[j]` is 1 when slot j is valid, its index is at or below the offender's, and it is not squashed. The offender's `out_tgt` slice is its `ctgt`; every other forwarded slice is that slot's `ptgt`.
- R8: With no mispredict in the group, every valid slot is forwarded with its `ptgt`, `out_sq` is 0 and `rd_valid` is 0.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. It does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | W | Slot occupied |
| in_tid | input | W*TID_W | Thread number per slot |
| in_seq | input | W*SEQ_W | Sequence number per slot |
| in_ctrl | input | W | Slot is a control transfer |
| in_direct | input | W | Target is PC-relative |
| in_uncond | input | W | Control transfer is unconditional |
| in_ptaken | input | W | Predictor said taken |
| in_ptgt | input | W*PC_W | Predicted target per slot |
| in_ctgt | input | W*PC_W | Decode-computed target, or fall-through PC for non-control slots |
| out_valid | output | W | Slot forwarded downstream |
| out_tgt | output | W*PC_W | Target forwarded per slot |
| out_sq | output | W | Slot squashed by this cycle's redirect |
| rd_valid | output | 1 | Redirect (mispredict and squash) to fetch |
| rd_kind | output | 1 | 0 = target mispredict, 1 = control mispredict |
| rd_tid | output | TID_W | Offender's thread |
| rd_seq | output | SEQ_W | Offender's sequence number |
| rd_npc | output | PC_W | Correct next PC |
| rd_taken | output | 1 | Redirect is taken |
| cnt_res | output | CNT_W | Resolved-branch counter |
| cnt_bm | output | CNT_W | Target-mispredict counter |
| cnt_cm | output | CNT_W | Control-mispredict counter |

## Verification
The bench builds the unit with W=4, TID_W=2, SEQ_W=16, PC_W=32 and CNT_W=16. Four slots let the offender land at each index, with older and younger neighbours on both sides, and let two mispredicts compete within one group. Two thread bits allow same-thread and other-thread slots to interleave, which exercises the squash filter. Random groups with monotonic sequence numbers run alongside directed groups for equal sequence numbers, competing mispredicts and the no-mispredict path.

// File: rtl/brx_pkg.sv
package brx_pkg;
  // Kind of redirect sent back to fetch
  typedef enum logic {
    RD_TARGET  = 1'b0,
    RD_CONTROL = 1'b1
  } rd_kind_e;
endpackage

// File: rtl/brx_slot_eval.sv
// Classifies one decode slot: resolvable branch, target mispredict, control mispredict.
module brx_slot_eval #(
  parameter int PC_W = 32
) (
  input  logic            valid,
  input  logic            ctrl,
  input  logic            direct,
  input  logic            uncond,
  input  logic            ptaken,
  input  logic [PC_W-1:0] ptgt,
  input  logic [PC_W-1:0] ctgt,
  output logic            resolvable,
  output logic            tgt_mis,
  output logic            ctl_mis
);
  assign resolvable = valid & ctrl & direct & uncond;
  assign tgt_mis    = resolvable & (ptgt != ctgt);
  assign ctl_mis    = valid & ptaken & ~ctrl;
endmodule

// File: rtl/brx_pick.sv
// Lowest-index priority pick of the offending slot.
module brx_pick #(
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input  logic [W-1:0]     mis,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     upto
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (!found && mis[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < W; i++) begin
      upto[i] = !found || (IDX_W'(i) <= idx);
    end
  end
endmodule

// File: rtl/brx_squash.sv
// Flags same-thread slots younger than the offender.
module brx_squash #(
  parameter int W     = 4,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16
) (
  input  logic               found,
  input  logic [W-1:0]       valid,
  input  logic [W*TID_W-1:0] tid,
  input  logic [W*SEQ_W-1:0] seq,
  input  logic [TID_W-1:0]   off_tid,
  input  logic [SEQ_W-1:0]   off_seq,
  output logic [W-1:0]       sq
);
  for (genvar g = 0; g < W; g++) begin : g_sq
    assign sq[g] = found & valid[g]
                 & (tid[g*TID_W +: TID_W] == off_tid)
                 & (seq[g*SEQ_W +: SEQ_W] > off_seq);
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int W     = 4,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       in_valid,
  input  logic [W*TID_W-1:0] in_tid,
  input  logic [W*SEQ_W-1:0] in_seq,
  input  logic [W-1:0]       in_ctrl,
  input  logic [W-1:0]       in_direct,
  input  logic [W-1:0]       in_uncond,
  input  logic [W-1:0]       in_ptaken,
  input  logic [W*PC_W-1:0]  in_ptgt,
  input  logic [W*PC_W-1:0]  in_ctgt,
  output logic [W-1:0]       out_valid,
  output logic [W*PC_W-1:0]  out_tgt,
  output logic [W-1:0]       out_sq,
  output logic               rd_valid,
  output logic               rd_kind,
  output logic [TID_W-1:0]   rd_tid,
  output logic [SEQ_W-1:0]   rd_seq,
  output logic [PC_W-1:0]    rd_npc,
  output logic               rd_taken,
  output logic [CNT_W-1:0]   cnt_res,
  output logic [CNT_W-1:0]   cnt_bm,
  output logic [CNT_W-1:0]   cnt_cm
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]      resolvable, tgt_mis, ctl_mis;
  logic              found;
  logic [IDX_W-1:0]  idx;
  logic [W-1:0]      upto, sq;
  logic [TID_W-1:0]  off_tid;
  logic [SEQ_W-1:0]  off_seq;
  logic [PC_W-1:0]   off_ctgt;
  rd_kind_e          off_kind;
  logic [CNT_W-1:0]  inc_res;
  logic [W-1:0]      fwd;
  logic [W*PC_W-1:0] tgt;

  for (genvar g = 0; g < W; g++) begin : g_slot
    brx_slot_eval #(.PC_W(PC_W)) u_eval (
      .valid      (in_valid[g]),
      .ctrl       (in_ctrl[g]),
      .direct     (in_direct[g]),
      .uncond     (in_uncond[g]),
      .ptaken     (in_ptaken[g]),
      .ptgt       (in_ptgt[g*PC_W +: PC_W]),
      .ctgt       (in_ctgt[g*PC_W +: PC_W]),
      .resolvable (resolvable[g]),
      .tgt_mis    (tgt_mis[g]),
      .ctl_mis    (ctl_mis[g])
    );
    assign fwd[g] = in_valid[g] & upto[g] & ~sq[g];
    assign tgt[g*PC_W +: PC_W] = (found && (idx == IDX_W'(g)))
                               ? in_ctgt[g*PC_W +: PC_W]
                               : in_ptgt[g*PC_W +: PC_W];
  end

  brx_pick #(.W(W), .IDX_W(IDX_W)) u_pick (
    .mis   (tgt_mis | ctl_mis),
    .found (found),
    .idx   (idx),
    .upto  (upto)
  );

  assign off_tid  = in_tid[idx*TID_W +: TID_W];
  assign off_seq  = in_seq[idx*SEQ_W +: SEQ_W];
  assign off_ctgt = in_ctgt[idx*PC_W +: PC_W];
  assign off_kind = ctl_mis[idx] ? RD_CONTROL : RD_TARGET;

  brx_squash #(.W(W), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_squash (
    .found   (found),
    .valid   (in_valid),
    .tid     (in_tid),
    .seq     (in_seq),
    .off_tid (off_tid),
    .off_seq (off_seq),
    .sq      (sq)
  );

  always_comb begin
    inc_res = '0;
    for (int i = 0; i < W; i++) begin
      if (resolvable[i] && upto[i]) inc_res = inc_res + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_tgt   <= '0;
      out_sq    <= '0;
      rd_valid  <= 1'b0;
      rd_kind   <= 1'b0;
      rd_tid    <= '0;
      rd_seq    <= '0;
      rd_npc    <= '0;
      rd_taken  <= 1'b0;
      cnt_res   <= '0;
      cnt_bm    <= '0;
      cnt_cm    <= '0;
    end else begin
      out_valid <= fwd;
      out_tgt   <= tgt;
      out_sq    <= sq;
      rd_valid  <= found;
      rd_kind   <= off_kind;
      rd_tid    <= off_tid;
      rd_seq    <= off_seq;
      rd_npc    <= off_ctgt;
      rd_taken  <= (off_kind == RD_TARGET);
      cnt_res   <= cnt_res + inc_res;
      if (found && off_kind == RD_TARGET)  cnt_bm <= cnt_bm + CNT_W'(1);
      if (found && off_kind == RD_CONTROL) cnt_cm <= cnt_cm + CNT_W'(1);
    end
  end
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk #(
  parameter int W     = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     out_valid,
  input logic [W-1:0]     out_sq,
  input logic             rd_valid,
  input logic             rd_kind,
  input logic             rd_taken,
  input logic [CNT_W-1:0] cnt_res,
  input logic [CNT_W-1:0] cnt_bm,
  input logic [CNT_W-1:0] cnt_cm
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_clear_chk: assert (out_valid == '0 && out_sq == '0 && !rd_valid
                               && cnt_res == '0 && cnt_bm == '0 && cnt_cm == '0)
        else $error("reset state not clear");
    end
  end

  // R7
  fwd_not_sq_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid & out_sq) == '0);

  // R6
  sq_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> out_sq == '0);

  // R3
  tgt_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_kind) |-> rd_taken);

  // R4
  ctl_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_kind) |-> !rd_taken);

  // R3
  bm_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_bm != $past(cnt_bm)) |-> (rd_valid && !rd_kind
                                   && cnt_bm == CNT_W'($past(cnt_bm) + 1'b1)));

  // R4
  cm_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_cm != $past(cnt_cm)) |-> (rd_valid && rd_kind
                                   && cnt_cm == CNT_W'($past(cnt_cm) + 1'b1)));

  // R5
  one_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_bm != $past(cnt_bm)) |-> (cnt_cm == $past(cnt_cm)));
endmodule

bind brx_unit brx_unit_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_sq    (out_sq),
  .rd_valid  (rd_valid),
  .rd_kind   (rd_kind),
  .rd_taken  (rd_taken),
  .cnt_res   (cnt_res),
  .cnt_bm    (cnt_bm),
  .cnt_cm    (cnt_cm)
);

// File: tb/tb_brx_unit.sv
`timescale 1ns/1ps
module tb_brx_unit;
  localparam int W     = 4;
  localparam int TID_W = 2;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [W-1:0]       in_valid, in_ctrl, in_direct, in_uncond, in_ptaken;
  logic [W*TID_W-1:0] in_tid;
  logic [W*SEQ_W-1:0] in_seq;
  logic [W*PC_W-1:0]  in_ptgt, in_ctgt;
  logic [W-1:0]       out_valid, out_sq;
  logic [W*PC_W-1:0]  out_tgt;
  logic               rd_valid, rd_kind, rd_taken;
  logic [TID_W-1:0]   rd_tid;
  logic [SEQ_W-1:0]   rd_seq;
  logic [PC_W-1:0]    rd_npc;
  logic [CNT_W-1:0]   cnt_res, cnt_bm, cnt_cm;

  brx_unit #(.W(W), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq),
    .in_ctrl(in_ctrl), .in_direct(in_direct), .in_uncond(in_uncond),
    .in_ptaken(in_ptaken), .in_ptgt(in_ptgt), .in_ctgt(in_ctgt),
    .out_valid(out_valid), .out_tgt(out_tgt), .out_sq(out_sq),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_tid(rd_tid), .rd_seq(rd_seq),
    .rd_npc(rd_npc), .rd_taken(rd_taken),
    .cnt_res(cnt_res), .cnt_bm(cnt_bm), .cnt_cm(cnt_cm)
  );

  // Per-slot stimulus
  logic [W-1:0]       s_v, s_c, s_d, s_u, s_p;
  logic [TID_W-1:0]   s_tid [W];
  logic [SEQ_W-1:0]   s_seq [W];
  logic [PC_W-1:0]    s_pt  [W];
  logic [PC_W-1:0]    s_ct  [W];

  always_comb begin
    in_valid = s_v; in_ctrl = s_c; in_direct = s_d; in_uncond = s_u; in_ptaken = s_p;
    for (int i = 0; i < W; i++) begin
      in_tid[i*TID_W +: TID_W] = s_tid[i];
      in_seq[i*SEQ_W +: SEQ_W] = s_seq[i];
      in_ptgt[i*PC_W +: PC_W]  = s_pt[i];
      in_ctgt[i*PC_W +: PC_W]  = s_ct[i];
    end
  end

  // Expected values
  logic [W-1:0]     e_fwd, e_sq;
  logic [PC_W-1:0]  e_tgt [W];
  logic             e_rdv, e_kind, e_taken;
  logic [TID_W-1:0] e_tid;
  logic [SEQ_W-1:0] e_seq;
  logic [PC_W-1:0]  e_npc;
  logic [CNT_W-1:0] e_res = '0, e_bm = '0, e_cm = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_slots();
    s_v = '0; s_c = '0; s_d = '0; s_u = '0; s_p = '0;
    for (int i = 0; i < W; i++) begin
      s_tid[i] = '0; s_seq[i] = '0; s_pt[i] = '0; s_ct[i] = '0;
    end
  endtask

  task automatic set_slot(input int i, input bit v, input int tid, input int seq,
                          input bit c, input bit d, input bit u, input bit p,
                          input logic [PC_W-1:0] pt, input logic [PC_W-1:0] ct);
    s_v[i] = v; s_tid[i] = TID_W'(tid); s_seq[i] = SEQ_W'(seq);
    s_c[i] = c; s_d[i] = d; s_u[i] = u; s_p[i] = p; s_pt[i] = pt; s_ct[i] = ct;
  endtask

  // Model built from the requirements
  task automatic predict();
    bit found = 0;
    int off = 0;
    for (int i = 0; i < W; i++) begin
      if (!found && s_v[i]) begin
        bit res = s_c[i] & s_d[i] & s_u[i];
        bit bm  = res && (s_ct[i] != s_pt[i]);
        bit cm  = s_p[i] && !s_c[i];
        if (res) e_res = e_res + 1'b1;
        if (bm || cm) begin
          found = 1; off = i; e_kind = cm;
        end
      end
    end
    e_rdv = found;
    if (found) begin
      e_tid = s_tid[off]; e_seq = s_seq[off]; e_npc = s_ct[off]; e_taken = !e_kind;
      if (e_kind) e_cm = e_cm + 1'b1; else e_bm = e_bm + 1'b1;
    end
    for (int j = 0; j < W; j++) begin
      e_sq[j]  = found && s_v[j] && (s_tid[j] == s_tid[off]) && (s_seq[j] > s_seq[off]);
      e_fwd[j] = s_v[j] && (!found || j <= off) && !e_sq[j];
      e_tgt[j] = (found && j == off) ? s_ct[j] : s_pt[j];
    end
  endtask

  task automatic compare();
    chk(out_valid == e_fwd, "R7", "out_valid", out_valid, e_fwd);
    chk(out_sq == e_sq, "R6", "out_sq", out_sq, e_sq);
    chk(rd_valid == e_rdv, "R5", "rd_valid", rd_valid, e_rdv);
    for (int j = 0; j < W; j++)
      if (e_fwd[j])
        chk(out_tgt[j*PC_W +: PC_W] == e_tgt[j], "R7", "out_tgt",
            out_tgt[j*PC_W +: PC_W], e_tgt[j]);
    if (e_rdv) begin
      chk(rd_kind == e_kind, e_kind ? "R4" : "R3", "rd_kind", rd_kind, e_kind);
      chk(rd_taken == e_taken, e_kind ? "R4" : "R3", "rd_taken", rd_taken, e_taken);
      chk(rd_npc == e_npc, e_kind ? "R4" : "R3", "rd_npc", rd_npc, e_npc);
      chk(rd_seq == e_seq, "R3", "rd_seq", rd_seq, e_seq);
      chk(rd_tid == e_tid, "R3", "rd_tid", rd_tid, e_tid);
    end
    chk(cnt_res == e_res, "R2", "cnt_res", cnt_res, e_res);
    chk(cnt_bm == e_bm, "R3", "cnt_bm", cnt_bm, e_bm);
    chk(cnt_cm == e_cm, "R4", "cnt_cm", cnt_cm, e_cm);
  endtask

  task automatic step();
    predict();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    clear_slots();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == '0 && out_sq == '0 && !rd_valid, "R1", "outputs in reset",
        {out_valid, out_sq, rd_valid}, 0);
    chk(cnt_res == '0 && cnt_bm == '0 && cnt_cm == '0, "R1", "counters in reset",
        {cnt_res, cnt_bm, cnt_cm}, 0);
    rst = 1'b0;

    // R8: no mispredict, two resolvable branches matching
    set_slot(0, 1, 0, 1, 1, 1, 1, 1, 32'h100, 32'h100);
    set_slot(1, 1, 1, 2, 0, 0, 0, 0, 32'h104, 32'h104);
    set_slot(2, 1, 0, 3, 1, 1, 1, 1, 32'h200, 32'h200);
    set_slot(3, 1, 0, 4, 1, 0, 0, 0, 32'h300, 32'h208);
    step();
    chk(!rd_valid && out_sq == '0 && out_valid == 4'b1111, "R8", "clean group",
        {rd_valid, out_sq, out_valid}, 4'b1111);

    // R3/R6/R7: target mispredict in slot 1, all thread 0
    set_slot(0, 1, 0, 10, 0, 0, 0, 0, 32'h400, 32'h404);
    set_slot(1, 1, 0, 11, 1, 1, 1, 1, 32'h500, 32'h540);
    set_slot(2, 1, 0, 12, 0, 0, 0, 0, 32'h544, 32'h548);
    set_slot(3, 1, 0, 13, 1, 1, 1, 1, 32'h600, 32'h610);
    predict();
    // R9: nothing changes before the edge
    #1 chk(rd_valid == 1'b0, "R9", "rd_valid before edge", rd_valid, 0);
    @(negedge clk);
    compare();
    chk(rd_seq == 16'd11 && out_sq == 4'b1100 && out_valid == 4'b0011, "R6",
        "slot1 offender", {rd_seq, out_sq, out_valid}, {16'd11, 4'b1100, 4'b0011});
    chk(out_tgt[PC_W +: PC_W] == 32'h540, "R7", "corrected target",
        out_tgt[PC_W +: PC_W], 32'h540);

    // R4/R5: control mispredict slot 0 beats target mispredict slot 2
    set_slot(0, 1, 2, 20, 0, 0, 0, 1, 32'h700, 32'h704);
    set_slot(1, 1, 3, 21, 1, 1, 1, 1, 32'h800, 32'h800);
    set_slot(2, 1, 3, 22, 1, 1, 1, 1, 32'h900, 32'h990);
    set_slot(3, 0, 2, 23, 0, 0, 0, 0, 32'h0, 32'h0);
    step();
    chk(rd_kind == 1'b1 && rd_npc == 32'h704 && !rd_taken, "R4", "control redirect",
        {rd_kind, rd_npc, rd_taken}, {1'b1, 32'h704, 1'b0});
    chk(cnt_bm == 16'd1 && out_valid == 4'b0001, "R5", "first mispredict only",
        {cnt_bm, out_valid}, {16'd1, 4'b0001});

    // R6: equal sequence and other thread untouched
    set_slot(0, 1, 1, 30, 1, 1, 1, 1, 32'hA00, 32'hA80);
    set_slot(1, 1, 0, 31, 0, 0, 0, 0, 32'hA04, 32'hA04);
    set_slot(2, 1, 1, 30, 0, 0, 0, 0, 32'hA08, 32'hA08);
    set_slot(3, 1, 1, 35, 0, 0, 0, 0, 32'hA0C, 32'hA0C);
    step();
    chk(out_sq == 4'b1000, "R6", "equal seq and other thread kept", out_sq, 4'b1000);

    // Random groups (R2..R8)
    base = 100;
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < W; i++) begin
        logic [PC_W-1:0] pt = $urandom;
        bit mis = ($urandom % 4) == 0;
        set_slot(i, ($urandom % 8) != 0, ($urandom % 3 == 0) ? int'($urandom % 4) : 0,
                 base + i, $urandom % 2, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 3) == 0, pt, mis ? (pt ^ (32'h1 << ($urandom % 32))) : pt);
      end
      base = base + W + int'($urandom % 3);
      step();
    end

    finish_run();
  end
endmodule